// File: doc/BRIEF.md
# Dual-Slot PCM Serial Port

This block is the serial side of a two-channel telephony codec. Each 8 kHz frame carries two 8-bit voice samples on one shared transmit line and one shared receive line. A bit clock and a frame sync pace the line. The block runs entirely in the chip's system clock domain and oversamples the bit clock and frame sync. Every line event therefore becomes a one-cycle strobe. The system clock must give each bit-clock half period at least two system cycles.

The port measures how long frame sync stays high, counted in bit-clock rising edges, and decides from that between long-frame and short-frame timing. The decision takes effect at the start of the next frame. The current frame uses the timing that was latched when it began. Two transmit bytes are shifted out, most significant bit first, in the first two 8-bit slots. Two receive bytes are gathered from the same two slots. A swap input chooses which internal channel owns the first slot. A mode input parks the port for a framing scheme that is not handled here; the port then stays silent.

The state machines are as follows. The frame-sync width tracker has three states: `FSW_LOW`, `FSW_ONE` and `FSW_MANY`. Its transitions are LOW to ONE when sync is first seen high (this marks the frame start), ONE to MANY when sync is still high, ONE to LOW when sync drops (the mode becomes short), and MANY to LOW when sync drops (the mode becomes long). The slot sequencer has three states: `SLT_IDLE`, `SLT_ARM` and `SLT_SHIFT`. Its transitions are:
- IDLE to SHIFT on a long-timing start.
- IDLE to ARM on a short-timing start.
- ARM to SHIFT on the next rising edge.
- SHIFT to SHIFT to advance a bit, or to reload on the last bit when a long start or a pending short start is present.
- SHIFT to ARM on a short start that arrives on the last bit.
- SHIFT to IDLE after the last bit.
- Any state to IDLE while the silent mode is selected.

Top module: `pcm_dual_port`

## Requirements
- R1: The port sends 16 bits per frame, with the first-slot byte before the second-slot byte and each byte sent from bit 7 down to bit 0. `dx` takes a new bit one system clock after a bit-clock rising edge is detected.
- R2: `dx_oe` is 1 during exactly the 16 active bit periods of a frame and 0 at all other times. `dx` is 0 whenever `dx_oe` is 0.
- R3: If frame sync is sampled high on exactly one bit-clock rising edge, `frame_long` becomes 0. If it is sampled high on two or more rising edges, `frame_long` becomes 1. The update happens at the rising edge where sync is first sampled low. After reset, `frame_long` is 1.
- R4: A change of the detected timing affects only frames that start after the change. The frame during which the change was detected keeps the timing that was latched at its start.
- R5: With long timing, the first data bit is driven on the same rising edge where frame sync is first sampled high.
- R6: With short timing, the first data bit is driven on the rising edge that follows the edge where frame sync is first sampled high.
- R7: `dr` is sampled on bit-clock falling edges during the active bits. Once the 16th bit has been sampled, both channel receive registers are updated and `rx_valid` is high for exactly one system clock.
- R8: With `sel_swap` = 0, channel 0 owns the first slot and channel 1 owns the second slot, in both directions. With `sel_swap` = 1, the mapping is reversed. The swap setting is latched on the frame's first data bit and applies to that whole frame.
- R9: Frames of only 16 bit periods can run back to back with no gap, in both timings, including a switch from long to short timing.
- R10: While `sel_gci` = 1, `dx_oe` stays 0, `rx_valid` never pulses, and the receive registers keep their values.
- R11: After reset, `dx_oe`, `dx`, `rx_valid`, `rx_ch0` and `rx_ch1` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Line bit clock, oversampled |
| fsync | input | 1 | 8 kHz frame sync |
| dr | input | 1 | Serial receive data |
| tx_ch0 | input | 8 | Channel 0 transmit sample |
| tx_ch1 | input | 8 | Channel 1 transmit sample |
| sel_gci | input | 1 | 1 = silent mode (no line activity) |
| sel_swap | input | 1 | 1 = channel 1 in first slot |
| dx | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Transmit output enable |
| rx_ch0 | output | 8 | Channel 0 received sample |
| rx_ch1 | output | 8 | Channel 1 received sample |
| rx_valid | output | 1 | One-cycle strobe when both received samples are updated |
| frame_long | output | 1 | Detected timing, 1 = long |

## Verification
The two functions that can coincide are the end of one frame's second slot and the start of the next frame. At the lowest bit-clock rate, the rising edge that would close a frame is also the edge that opens the next one, or the short-timing sync pulse lands on the final data bit. The bench provokes both cases with runs of 16-period frames in long timing, in short timing and across a long-to-short switch. It judges them by checking `dx_oe` and `dx` against a per-period schedule built by bench functions, and by confirming that every frame produces exactly one receive strobe with the expected bytes.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    typedef enum logic [1:0] {
        FSW_LOW  = 2'd0,
        FSW_ONE  = 2'd1,
        FSW_MANY = 2'd2
    } fsw_state_e;

    typedef enum logic [1:0] {
        SLT_IDLE  = 2'd0,
        SLT_ARM   = 2'd1,
        SLT_SHIFT = 2'd2
    } slot_state_e;

endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fsync,
    input  logic dr,
    output logic bclk_rise,
    output logic bclk_fall,
    output logic fs_s,
    output logic dr_s
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] bclk_pipe;
    logic [STAGES-2:0] fs_pipe;
    logic [STAGES-2:0] dr_pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_pipe <= '0;
            fs_pipe   <= '0;
            dr_pipe   <= '0;
        end else begin
            bclk_pipe <= {bclk_pipe[STAGES-2:0], bclk};
            fs_pipe   <= {fs_pipe[STAGES-2:0] , fsync} >> 0;
            dr_pipe   <= {dr_pipe[STAGES-2:0] , dr} >> 0;
        end
    end

    assign bclk_rise = bclk_pipe[LAST-1] & ~bclk_pipe[LAST];
    assign bclk_fall = ~bclk_pipe[LAST-1] & bclk_pipe[LAST];
    assign fs_s      = fs_pipe[STAGES-2];
    assign dr_s      = dr_pipe[STAGES-2];

endmodule

// File: rtl/pcm_fs_width.sv
module pcm_fs_width
    import pcm_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_rise,
    input  logic fs_s,
    output logic frame_start,
    output logic frame_long
);
    fsw_state_e st_q, st_d;
    logic       upd;
    logic       upd_val;
    logic       long_q;

    always_comb begin
        st_d        = st_q;
        frame_start = 1'b0;
        upd         = 1'b0;
        upd_val     = long_q;
        if (bclk_rise) begin
            unique case (st_q)
                FSW_LOW: begin
                    if (fs_s) begin
                        st_d        = FSW_ONE;
                        frame_start = 1'b1;
                    end
                end
                FSW_ONE: begin
                    if (fs_s) begin
                        st_d = FSW_MANY;
                    end else begin
                        st_d    = FSW_LOW;
                        upd     = 1'b1;
                        upd_val = 1'b0;
                    end
                end
                FSW_MANY: begin
                    if (!fs_s) begin
                        st_d    = FSW_LOW;
                        upd     = 1'b1;
                        upd_val = 1'b1;
                    end
                end
                default: st_d = FSW_LOW;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FSW_LOW;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   long_q <= 1'b1;
        else if (upd) long_q <= upd_val;
    end

    assign frame_long = long_q;

    AST_SHORT_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_rise && st_q == FSW_ONE && !fs_s) |=> !frame_long); // R3
    AST_LONG_ON_MANY: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_rise && st_q == FSW_MANY && !fs_s) |=> frame_long); // R3
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_rise |=> $stable(frame_long)); // R4

endmodule

// File: rtl/pcm_slot_ctrl.sv
module pcm_slot_ctrl
    import pcm_port_pkg::*;
#(
    parameter int FRAME_BITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_rise,
    input  logic bclk_fall,
    input  logic frame_start,
    input  logic frame_long,
    input  logic gci_mode,
    output logic load,
    output logic advance,
    output logic rx_cap,
    output logic rx_last,
    output logic oe
);
    localparam int CNT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    slot_state_e st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic pend_q, pend_d;
    logic oe_q;

    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        pend_d  = pend_q;
        load    = 1'b0;
        advance = 1'b0;
        if (gci_mode) begin
            st_d   = SLT_IDLE;
            pend_d = 1'b0;
        end else if (bclk_rise) begin
            unique case (st_q)
                SLT_IDLE: begin
                    if (frame_start) begin
                        if (frame_long) load = 1'b1;
                        else            st_d = SLT_ARM;
                    end
                end
                SLT_ARM: load = 1'b1;
                SLT_SHIFT: begin
                    if (cnt_q == LAST_BIT) begin
                        if (frame_start && frame_long)  load = 1'b1;
                        else if (frame_start)           begin st_d = SLT_ARM; pend_d = 1'b0; end
                        else if (pend_q)                load = 1'b1;
                        else                            st_d = SLT_IDLE;
                    end else begin
                        advance = 1'b1;
                        cnt_d   = cnt_q + 1'b1;
                        if (frame_start && !frame_long) pend_d = 1'b1;
                    end
                end
                default: st_d = SLT_IDLE;
            endcase
            if (load) begin
                st_d   = SLT_SHIFT;
                cnt_d  = '0;
                pend_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= SLT_IDLE;
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= (st_d == SLT_SHIFT);
    end

    assign oe      = oe_q;
    assign rx_cap  = bclk_fall && !gci_mode && (st_q == SLT_SHIFT);
    assign rx_last = rx_cap && (cnt_q == LAST_BIT);

    AST_GCI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        gci_mode |=> !oe); // R10
    AST_OE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(bclk_rise)); // R5
    AST_OE_OFF_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(oe) && !$past(gci_mode)) |-> $past(bclk_rise)); // R2

endmodule

// File: rtl/pcm_shift_path.sv
module pcm_shift_path #(
    parameter int SLOT_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 advance,
    input  logic                 swap,
    input  logic [SLOT_BITS-1:0] tx0,
    input  logic [SLOT_BITS-1:0] tx1,
    input  logic                 rx_cap,
    input  logic                 rx_last,
    input  logic                 dr_s,
    output logic                 tx_bit,
    output logic [SLOT_BITS-1:0] rx0,
    output logic [SLOT_BITS-1:0] rx1,
    output logic                 rx_valid
);
    localparam int FRAME_BITS = 2 * SLOT_BITS;

    logic [FRAME_BITS-1:0] txs_q;
    logic [FRAME_BITS-1:0] rxs_q;
    logic [FRAME_BITS-1:0] rx_full;
    logic                  swap_q;

    assign rx_full = {rxs_q[FRAME_BITS-2:0], dr_s};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txs_q  <= '0;
            swap_q <= 1'b0;
        end else if (load) begin
            txs_q  <= swap ? {tx1, tx0} : {tx0, tx1};
            swap_q <= swap;
        end else if (advance) begin
            txs_q  <= {txs_q[FRAME_BITS-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxs_q    <= '0;
            rx0      <= '0;
            rx1      <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (rx_cap) rxs_q <= rx_full;
            if (rx_last) begin
                rx_valid <= 1'b1;
                if (swap_q) begin
                    rx0 <= rx_full[SLOT_BITS-1:0];
                    rx1 <= rx_full[FRAME_BITS-1:SLOT_BITS];
                end else begin
                    rx0 <= rx_full[FRAME_BITS-1:SLOT_BITS];
                    rx1 <= rx_full[SLOT_BITS-1:0];
                end
            end
        end
    end

    assign tx_bit = txs_q[FRAME_BITS-1];

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R7
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx0) && $stable(rx1))); // R10

endmodule

// File: rtl/pcm_dual_port.sv
module pcm_dual_port #(
    parameter int SLOT_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bclk,
    input  logic                 fsync,
    input  logic                 dr,
    input  logic [SLOT_BITS-1:0] tx_ch0,
    input  logic [SLOT_BITS-1:0] tx_ch1,
    input  logic                 sel_gci,
    input  logic                 sel_swap,
    output logic                 dx,
    output logic                 dx_oe,
    output logic [SLOT_BITS-1:0] rx_ch0,
    output logic [SLOT_BITS-1:0] rx_ch1,
    output logic                 rx_valid,
    output logic                 frame_long
);
    localparam int FRAME_BITS = 2 * SLOT_BITS;

    logic rise, fall, fs_s, dr_s;
    logic frame_start;
    logic load, advance, rx_cap, rx_last, oe;
    logic tx_bit;

    pcm_edge_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .dr(dr),
        .bclk_rise(rise), .bclk_fall(fall), .fs_s(fs_s), .dr_s(dr_s)
    );

    pcm_fs_width u_width (
        .clk(clk), .rst_n(rst_n), .bclk_rise(rise), .fs_s(fs_s),
        .frame_start(frame_start), .frame_long(frame_long)
    );

    pcm_slot_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .bclk_rise(rise), .bclk_fall(fall),
        .frame_start(frame_start), .frame_long(frame_long), .gci_mode(sel_gci),
        .load(load), .advance(advance), .rx_cap(rx_cap), .rx_last(rx_last), .oe(oe)
    );

    pcm_shift_path #(.SLOT_BITS(SLOT_BITS)) u_path (
        .clk(clk), .rst_n(rst_n), .load(load), .advance(advance), .swap(sel_swap),
        .tx0(tx_ch0), .tx1(tx_ch1), .rx_cap(rx_cap), .rx_last(rx_last), .dr_s(dr_s),
        .tx_bit(tx_bit), .rx0(rx_ch0), .rx1(rx_ch1), .rx_valid(rx_valid)
    );

    assign dx_oe = oe;
    assign dx    = oe & tx_bit;

    AST_DX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dx_oe |-> !dx); // R2
    AST_NO_VALID_GCI: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel_gci) && sel_gci |-> !rx_valid); // R10

endmodule

// File: tb/sim_pcm_dual_port.sv
`timescale 1ns/1ps
module sim_pcm_dual_port;
    localparam int NT  = 3000;
    localparam int NRX = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b0, fsync = 1'b0, dr = 1'b0, sel_gci = 1'b0, sel_swap = 1'b0;
    logic [7:0] tx_ch0 = '0, tx_ch1 = '0;
    logic dx, dx_oe, rx_valid, frame_long;
    logic [7:0] rx_ch0, rx_ch1;

    always #2 clk = ~clk;

    pcm_dual_port u0 (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .dr(dr),
        .tx_ch0(tx_ch0), .tx_ch1(tx_ch1), .sel_gci(sel_gci), .sel_swap(sel_swap),
        .dx(dx), .dx_oe(dx_oe), .rx_ch0(rx_ch0), .rx_ch1(rx_ch1),
        .rx_valid(rx_valid), .frame_long(frame_long)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    logic fs_a [NT];
    logic dr_a [NT];
    logic oe_e [NT];
    logic dx_e [NT];
    logic gci_a [NT];
    logic sw_a [NT];
    logic chk_m [NT];
    logic mode_e [NT];
    logic [7:0] t0_a [NT];
    logic [7:0] t1_a [NT];
    string tg_a [NT];

    logic [7:0] erx0 [NRX];
    logic [7:0] erx1 [NRX];
    string etag [NRX];
    int nexp = 0, nrx = 0;
    int tcur = 0;
    bit mdl_long = 1'b1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Model: schedule one frame of len bit periods
    task automatic add_frame(input int len, input int fsw, input bit gci, input bit sw,
                             input logic [7:0] a0, input logic [7:0] a1,
                             input logic [15:0] rxw, input string tag);
        bit used = mdl_long;
        int off = used ? 0 : 1;
        logic [15:0] word = sw ? {a1, a0} : {a0, a1};
        for (int p = 0; p < len; p++) begin
            fs_a[tcur+p]  = (p < fsw);
            gci_a[tcur+p] = gci;
            tg_a[tcur+p]  = gci ? "R10" : "R2";
        end
        if (!gci) begin
            for (int d = 0; d < 16; d++) begin
                oe_e[tcur+off+d] = 1'b1;
                dx_e[tcur+off+d] = word[15-d];
                dr_a[tcur+off+d] = rxw[15-d];
                tg_a[tcur+off+d] = tag;
            end
            for (int t = tcur + off; t < NT; t++) begin
                t0_a[t] = a0; t1_a[t] = a1; sw_a[t] = sw;
            end
            erx0[nexp] = sw ? rxw[7:0]  : rxw[15:8];
            erx1[nexp] = sw ? rxw[15:8] : rxw[7:0];
            etag[nexp] = sw ? "R8" : "R7";
            nexp++;
        end
        mdl_long = (fsw >= 2);
        chk_m[tcur+len-1]  = 1'b1;
        mode_e[tcur+len-1] = mdl_long;
        tcur += len;
    endtask

    function automatic logic [7:0] rb();
        return 8'($urandom);
    endfunction

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (nrx < nexp) begin
                check(rx_ch0 === erx0[nrx], etag[nrx], rx_ch0, erx0[nrx]);
                check(rx_ch1 === erx1[nrx], etag[nrx], rx_ch1, erx1[nrx]);
            end else begin
                check(1'b0, "R10", nrx, nexp);
            end
            nrx++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1C0DE5));
        for (int t = 0; t < NT; t++) begin
            fs_a[t] = 0; dr_a[t] = 1'($urandom); oe_e[t] = 0; dx_e[t] = 0;
            gci_a[t] = 0; sw_a[t] = 0; chk_m[t] = 0; mode_e[t] = 0;
            t0_a[t] = 0; t1_a[t] = 0; tg_a[t] = "R2";
        end
        // Long timing from reset
        for (int i = 0; i < 3; i++) add_frame(24, 6, 0, 0, rb(), rb(), 16'($urandom), "R5");
        // Short sync seen, current frame still long
        add_frame(24, 1, 0, 0, rb(), rb(), 16'($urandom), "R4");
        add_frame(24, 1, 0, 0, rb(), rb(), 16'($urandom), "R6");
        // Short back-to-back at 16 periods
        for (int i = 0; i < 4; i++) add_frame(16, 1, 0, 0, rb(), rb(), 16'($urandom), "R9");
        add_frame(17, 2, 0, 0, rb(), rb(), 16'($urandom), "R9");
        // Long back-to-back, then long-to-short switch with no gap
        for (int i = 0; i < 3; i++) add_frame(16, 3, 0, 0, rb(), rb(), 16'($urandom), "R9");
        add_frame(16, 1, 0, 0, rb(), rb(), 16'($urandom), "R9");
        add_frame(20, 1, 0, 0, rb(), rb(), 16'($urandom), "R9");
        // Swapped mapping
        add_frame(24, 5, 0, 1, 8'hA5, 8'h3C, 16'hF00F, "R8");
        add_frame(24, 2, 0, 1, rb(), rb(), 16'($urandom), "R8");
        add_frame(24, 2, 0, 0, rb(), rb(), 16'($urandom), "R8");
        // Silent mode
        add_frame(24, 1, 1, 0, rb(), rb(), 16'($urandom), "R10");
        add_frame(24, 4, 1, 1, rb(), rb(), 16'($urandom), "R10");
        add_frame(24, 3, 0, 0, rb(), rb(), 16'($urandom), "R10");
        // Constrained random frames
        for (int i = 0; i < 40; i++) begin
            int len = 18 + int'($urandom % 23);
            int fsw = ($urandom % 3 == 0) ? 1 : 2 + int'($urandom % (len - 3));
            add_frame(len, fsw, 0, 1'($urandom), rb(), rb(), 16'($urandom), "R1");
        end
        tcur += 4;

        repeat (3) @(negedge clk);
        check(dx_oe === 1'b0, "R11", dx_oe, 0);
        check(dx === 1'b0, "R11", dx, 0);
        check(rx_valid === 1'b0, "R11", rx_valid, 0);
        check(rx_ch0 === 8'h00 && rx_ch1 === 8'h00, "R11", {rx_ch0, rx_ch1}, 0);
        check(frame_long === 1'b1, "R3", frame_long, 1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        for (int t = 0; t < tcur; t++) begin
            bclk = 0; fsync = fs_a[t]; sel_gci = gci_a[t]; sel_swap = sw_a[t];
            tx_ch0 = t0_a[t]; tx_ch1 = t1_a[t];
            repeat (4) @(negedge clk);
            bclk = 1; dr = dr_a[t];
            repeat (4) @(negedge clk);
            check(dx_oe === oe_e[t], (oe_e[t] ? tg_a[t] : "R2"), dx_oe, oe_e[t]);
            check(dx === (oe_e[t] & dx_e[t]), (oe_e[t] ? tg_a[t] : "R2"), dx, oe_e[t] & dx_e[t]);
            if (chk_m[t]) check(frame_long === mode_e[t], "R3", frame_long, mode_e[t]);
        end
        bclk = 0;
        repeat (8) @(negedge clk);
        check(nrx == nexp, "R7", nrx, nexp);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule